// File: doc/BRIEF.md
# Start/Stop Flit Sequence Detector

This block sits behind a double-data-rate receiver. Each clock it gets two bits of the incoming serial line: an even bit, which is the earlier of the two in time, and an odd bit, which follows it. While it is hunting, it looks for an 8-bit start flit. When one arrives it opens a communication window for the downstream deserializer and decoders.

The receiver gives no guarantee that a flit begins on an even bit. The detector therefore accepts a start flit that ends on the odd bit of a cycle (aligned) and one that ends on the even bit (skewed by one bit). It reports which alignment it saw on a shift flag, and downstream logic uses that flag to reorder its bits. During the window the detector looks for the stop flit, but only in the alignment it latched. When the stop flit arrives it closes the window and returns to hunting. Dropping the enable abandons everything at once.

All outputs are registered. Each result appears one clock after the edge that samples the last bit of a flit.

Top module: `flit_seq_detect`

## Requirements
- R1: While reset is high, comm_active, shift, start_pulse and stop_pulse are all 0 after the next clock edge.
- R2: While hunting, if the eight most recent bits ending on the current odd bit equal the start flit 11011111 (first-received bit leftmost, the even bit of each pair taken before its odd bit), then after that edge start_pulse is 1, comm_active is 1 and shift is 0.
- R3: While hunting, if the eight most recent bits ending on the current even bit equal 11011111, then after that edge start_pulse is 1, comm_active is 1 and shift is 1.
- R4: start_pulse and stop_pulse are each high for exactly one cycle per detection. comm_active and shift hold their values for the whole window.
- R5: During the window, the stop flit 10111111 ending on an odd bit (shift 0) or on an even bit (shift 1) ends the window. After that edge stop_pulse is 1 and comm_active and shift are 0.
- R6: During the window, a stop flit in the alignment opposite to the latched shift value is ignored. comm_active stays 1 and no stop_pulse occurs.
- R7: A start flit received during the window produces no start_pulse and no change of shift. A stop flit received while hunting produces no stop_pulse.
- R8: A flit is found even when earlier bits formed a partial match that then failed. Detection depends only on the last eight bits received, so overlapping false starts cost nothing.
- R9: When en is low at an edge, comm_active, shift, start_pulse and stop_pulse are all 0 after that edge.
- R10: Bits presented while en is low, and bits received before en was last low, never take part in a later detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver divided clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Detector enable; low forces hunting and clears history |
| even_bit | input | 1 | Earlier bit of the current pair |
| odd_bit | input | 1 | Later bit of the current pair |
| comm_active | output | 1 | High while a start has been seen and no stop yet |
| shift | output | 1 | Latched alignment: 1 when the start flit ended on an even bit |
| start_pulse | output | 1 | One-cycle pulse on start detection |
| stop_pulse | output | 1 | One-cycle pulse on stop detection |

## Verification
The bench targets flits that straddle a cycle boundary. A design that looked only at whole pairs would miss the skewed start or report shift 0 for it. It sends stop flits in the wrong alignment during a window, which a detector that checks both alignments would wrongly accept. It also sends start flits preceded by repeated ones, so a state machine that throws away the failing pair instead of re-examining it would miss the real flit. Enable is toggled partway through a flit, so that stale history left behind after an enable drop would show up as a false start.

// File: rtl/flit_det_pkg.sv
package flit_det_pkg;

    localparam int FLIT_W = 8;
    localparam logic [FLIT_W-1:0] START_FLIT = 8'b1101_1111;
    localparam logic [FLIT_W-1:0] STOP_FLIT  = 8'b1011_1111;

    typedef enum logic {
        DET_HUNT = 1'b0,
        DET_COMM = 1'b1
    } det_state_e;

    // One sampled cycle of the line: even bit first in time.
    typedef struct packed {
        logic even_b;
        logic odd_b;
    } pair_t;

    // Match result for one flit code in both possible alignments.
    typedef struct packed {
        logic aligned;  // flit ends on the odd bit of this cycle
        logic skewed;   // flit ends on the even bit of this cycle
    } hit_t;

endpackage

// File: rtl/fd_history.sv
module fd_history
    import flit_det_pkg::*;
#(
    parameter int HIST_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  pair_t             pair,
    output logic [HIST_W-1:0] hist
);

    // Oldest bit at the MSB; each cycle shifts in even then odd.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist <= '0;
        end else begin
            hist <= {hist[HIST_W-3:0], pair.even_b, pair.odd_b};
        end
    end

endmodule

// File: rtl/fd_window_match.sv
module fd_window_match
    import flit_det_pkg::*;
#(
    parameter int               PAT_W = 8,
    parameter logic [PAT_W-1:0] CODE  = START_FLIT
) (
    input  logic [PAT_W-2:0] hist,
    input  pair_t            pair,
    output hit_t             hit
);

    logic [PAT_W-1:0] win_aligned;
    logic [PAT_W-1:0] win_skewed;

    always_comb begin
        win_aligned = {hist[PAT_W-3:0], pair.even_b, pair.odd_b};
        win_skewed  = {hist, pair.even_b};
        hit.aligned = (win_aligned == CODE);
        hit.skewed  = (win_skewed == CODE);
    end

endmodule

// File: rtl/fd_ctrl.sv
module fd_ctrl
    import flit_det_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  hit_t start_hit,
    input  hit_t stop_hit,
    output logic comm_active,
    output logic shift,
    output logic start_pulse,
    output logic stop_pulse
);

    det_state_e state;
    logic       stop_seen;

    always_comb begin
        stop_seen = shift ? stop_hit.skewed : stop_hit.aligned;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state       <= DET_HUNT;
            shift       <= 1'b0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            case (state)
                DET_HUNT: begin
                    if (start_hit.aligned || start_hit.skewed) begin
                        state       <= DET_COMM;
                        shift       <= start_hit.skewed;
                        start_pulse <= 1'b1;
                    end
                end
                DET_COMM: begin
                    if (stop_seen) begin
                        state      <= DET_HUNT;
                        shift      <= 1'b0;
                        stop_pulse <= 1'b1;
                    end
                end
                default: state <= DET_HUNT;
            endcase
        end
    end

    assign comm_active = (state == DET_COMM);

endmodule

// File: rtl/flit_seq_detect.sv
module flit_seq_detect
    import flit_det_pkg::*;
#(
    parameter int               PAT_W      = FLIT_W,
    parameter logic [PAT_W-1:0] START_CODE = START_FLIT,
    parameter logic [PAT_W-1:0] STOP_CODE  = STOP_FLIT
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic even_bit,
    input  logic odd_bit,
    output logic comm_active,
    output logic shift,
    output logic start_pulse,
    output logic stop_pulse
);

    localparam int HIST_W = PAT_W - 1;
    localparam int N_CODE = 2;

    pair_t             pair;
    logic [HIST_W-1:0] hist;
    hit_t              hits [N_CODE];

    assign pair = '{even_b: even_bit, odd_b: odd_bit};

    fd_history #(.HIST_W(HIST_W)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .clr  (!en),
        .pair (pair),
        .hist (hist)
    );

    // Index 0 hunts the opening flit, index 1 the closing flit.
    for (genvar g = 0; g < N_CODE; g++) begin : g_match
        localparam logic [PAT_W-1:0] CODE_G = (g == 0) ? START_CODE : STOP_CODE;
        fd_window_match #(.PAT_W(PAT_W), .CODE(CODE_G)) u_match (
            .hist (hist),
            .pair (pair),
            .hit  (hits[g])
        );
    end

    fd_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .start_hit   (hits[0]),
        .stop_hit    (hits[1]),
        .comm_active (comm_active),
        .shift       (shift),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse)
    );

endmodule

// File: rtl/fd_checker.sv
module fd_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic comm_active,
    input logic shift,
    input logic start_pulse,
    input logic stop_pulse
);

    // R4: the two detect pulses never coincide.
    p_pulses_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && stop_pulse));

    // R2: a start pulse always opens the window.
    p_start_opens_r2: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> comm_active);

    // R4: the window only opens together with a start pulse.
    p_open_needs_start_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(comm_active) |-> start_pulse);

    // R5: a stop pulse leaves the detector hunting with alignment cleared.
    p_stop_closes_r5: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |-> (!comm_active && !shift));

    // R5: the window closes only on a stop or an enable drop.
    p_close_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(comm_active) |-> (stop_pulse || !$past(en)));

    // R4: the alignment stays fixed while the window is open.
    p_shift_held_r4: assert property (@(posedge clk) disable iff (rst)
        (comm_active && $past(comm_active)) |-> $stable(shift));

    // R3: the alignment flag only exists inside a window.
    p_shift_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        shift |-> comm_active);

    // R9: enable low clears every output.
    p_disable_clears_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (!comm_active && !shift && !start_pulse && !stop_pulse));

    // R7: no second start inside an open window.
    p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (comm_active && $past(comm_active)) |-> !start_pulse);

endmodule

bind flit_seq_detect fd_checker u_fd_checker (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .comm_active (comm_active),
    .shift       (shift),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse)
);

// File: tb/test_flit_seq_detect.sv
`timescale 1ns/1ps
module test_flit_seq_detect;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic even_bit = 1'b0;
    logic odd_bit = 1'b0;
    logic comm_active, shift, start_pulse, stop_pulse;

    int checks = 0;
    int errors = 0;
    string req = "R1";

    // Reference model state
    bit   hist_q[$];
    logic m_comm = 0, m_shift = 0, m_start = 0, m_stop = 0;
    localparam logic [7:0] START_P = 8'b1101_1111;
    localparam logic [7:0] STOP_P  = 8'b1011_1111;

    always #10 clk = ~clk;

    flit_seq_detect i_flit_seq_detect (
        .clk(clk), .rst(rst), .en(en),
        .even_bit(even_bit), .odd_bit(odd_bit),
        .comm_active(comm_active), .shift(shift),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse)
    );

    // True if the 8 bits ending 'back' bits before the newest equal pat.
    function automatic bit seen(int back, logic [7:0] pat);
        int n = hist_q.size();
        if (n < 8 + back) return 0;
        for (int i = 0; i < 8; i++)
            if (hist_q[n - back - 8 + i] != pat[7-i]) return 0;
        return 1;
    endfunction

    task automatic model_step(bit r, bit e, bit ev, bit od);
        m_start = 0;
        m_stop  = 0;
        if (r || !e) begin
            hist_q.delete();
            m_comm  = 0;
            m_shift = 0;
        end else begin
            hist_q.push_back(ev);
            hist_q.push_back(od);
            if (!m_comm) begin
                if (seen(0, START_P)) begin
                    m_comm = 1; m_shift = 0; m_start = 1;
                end else if (seen(1, START_P)) begin
                    m_comm = 1; m_shift = 1; m_start = 1;
                end
            end else if (m_shift ? seen(1, STOP_P) : seen(0, STOP_P)) begin
                m_comm = 0; m_shift = 0; m_stop = 1;
            end
            while (hist_q.size() > 9) void'(hist_q.pop_front());
        end
    endtask

    task automatic check1(string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
        end
    endtask

    task automatic cyc(bit r, bit e, bit ev, bit od);
        rst = r; en = e; even_bit = ev; odd_bit = od;
        @(posedge clk);
        model_step(r, e, ev, od);
        @(negedge clk);
        check1("comm_active", comm_active, m_comm);
        check1("shift", shift, m_shift);
        check1("start_pulse", start_pulse, m_start);
        check1("stop_pulse", stop_pulse, m_stop);
    endtask

    task automatic bits(string s);
        for (int i = 0; i + 1 < s.len(); i += 2)
            cyc(0, 1, s[i] == "1", s[i+1] == "1");
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        req = "R1";
        repeat (3) cyc(1, 0, 1, 1);
        cyc(1, 1, 1, 1);

        req = "R2";  // aligned start, then payload
        bits("0000110111110011");
        req = "R6";  // stop in the wrong (skewed) alignment is ignored
        bits("0101111111000000");
        req = "R7";  // start flit inside the window is ignored
        bits("1101111100");
        req = "R5";  // aligned stop closes the window
        bits("1011111100");
        req = "R7";  // stop flit while hunting is ignored
        bits("1011111100");

        req = "R3";  // start skewed by one bit
        bits("0110111111100000");
        req = "R6";  // aligned stop ignored under skew
        bits("0010111111000000");
        req = "R5";  // skewed stop closes
        bits("0101111111000000");

        req = "R8";  // overlapping partial matches before the real flit
        bits("1111011111");
        bits("111101011111110000");

        req = "R9";  // enable drop mid-window
        bits("110111110000");
        cyc(0, 0, 1, 1);
        cyc(0, 1, 0, 0);

        req = "R10"; // bits during enable low do not count
        cyc(0, 1, 1, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 1, 1);
        bits("11110000");
        bits("1101111100");
        req = "R4";
        bits("0000000010111111");

        req = "R2";  // biased random stream
        for (int k = 0; k < 600; k++)
            cyc(0, ($urandom % 50) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule